// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Flags

This block computes a one-byte result from an accumulator value and a second operand, and keeps a five-bit status register beside it. The operations are addition (with or without the stored carry), subtraction (with or without the stored borrow), increment and decrement of the accumulator, bitwise inversion of the accumulator, and a one-position left rotation in which the top bit wraps into both bit 0 and the carry.

The result and the candidate flag value are combinational from the inputs and the stored flags. The stored flags load the candidate value on a clock edge when the operation strobe is high, so a surrounding sequencer can issue one operation per cycle and chain multi-byte arithmetic through the stored carry. Subtraction runs through the same adder as addition by inverting the operand; the adder's carry-out is then inverted so the carry flag reads as a borrow.

Top module: `acc_alu`

## Requirements
- R1: Operation 0 (plain add) gives result = (A + B) mod 256 and carry = bit 8 of A + B; operation 1 (add with carry) also adds the stored carry as a third term.
- R2: Operation 2 (subtract) gives (A - B) mod 256 and operation 3 (subtract with borrow) gives (A - B - stored carry) mod 256; in both the carry flag is 1 exactly when the true difference is negative.
- R3: For operations 0 to 5 the auxiliary-carry flag is the carry out of bit 3 when the low nibbles of A, the adder operand and the carry-in are summed; for subtraction the adder operand is the inverted B and carry-in is 1 (subtract) or the inverted stored carry (subtract with borrow), with no inversion of the result.
- R4: For operations 0 to 5 the sign flag equals result bit 7 and the zero flag is 1 exactly when the result is 00h.
- R5: For operations 0 to 5 the parity flag is 1 exactly when the result holds an even number of one bits (3Ch gives 1, 45h gives 0).
- R6: Operation 4 gives A + 1 and operation 5 gives A - 1 (both mod 256, B ignored); they update sign, zero, auxiliary carry and parity but keep the carry flag.
- R7: Operation 6 gives the bitwise inverse of A and leaves all five flags unchanged.
- R8: Operation 7 gives {A[6:0], A[7]}, loads carry with A[7] and leaves sign, zero, auxiliary carry and parity unchanged.
- R9: The flag bits are ordered [4]=sign, [3]=zero, [2]=auxiliary carry, [1]=parity, [0]=carry; reset clears all five, and the stored flags take the candidate value at a rising edge only when the operation strobe is high, holding otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of the flag register |
| opValid | input | 1 | Commit the candidate flags at the next rising edge |
| opSel | input | 3 | Operation code 0 to 7 as listed in the requirements |
| accIn | input | 8 | Accumulator value A |
| operandIn | input | 8 | Second operand B |
| result | output | 8 | Combinational operation result |
| flagsNext | output | 5 | Combinational candidate flags |
| flagsOut | output | 5 | Stored flags |

## Verification
The bound checker watches every cycle that the stored flags load only under the strobe, that inversion keeps all flags and increment or decrement keep the carry, that rotation loads the carry from the top accumulator bit, and that zero, sign and parity agree with the result committed. The arithmetic values themselves, the auxiliary carry in the subtract forms and the borrow polarity, depend on operand values and chains of operations, so only the bench's behavioural model, run through the worked examples and long random sequences that carry flags forward between operations, can show them correct.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int FLAG_W  = 5;
  localparam int FLG_S   = 4;
  localparam int FLG_Z   = 3;
  localparam int FLG_AC  = 2;
  localparam int FLG_P   = 1;
  localparam int FLG_CY  = 0;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_INC = 3'd4,
    OP_DEC = 3'd5,
    OP_CPL = 3'd6,
    OP_RLC = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_CY   = 2'd2,
    CIN_NCY  = 2'd3
  } cinSel_e;

  typedef enum logic [1:0] {
    RES_SUM = 2'd0,
    RES_CPL = 2'd1,
    RES_ROT = 2'd2
  } resSel_e;

  typedef struct packed {
    logic    bConst;   // replace operand by zero
    logic    bInvert;  // invert adder operand
    cinSel_e cinSel;
    logic    borrow;   // invert carry-out
    resSel_e resSel;
    logic    wrArith;  // update S, Z, AC, P
    logic    wrCarry;  // update CY
  } aluStrobe_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [2:0]  opSel,
  output aluStrobe_t  strobe
);

  aluOp_e op;
  assign op = aluOp_e'(opSel);

  always_comb begin
    strobe = '{bConst: 1'b0, bInvert: 1'b0, cinSel: CIN_ZERO, borrow: 1'b0,
               resSel: RES_SUM, wrArith: 1'b1, wrCarry: 1'b1};
    unique case (op)
      OP_ADD: ;
      OP_ADC: strobe.cinSel = CIN_CY;
      OP_SUB: begin
        strobe.bInvert = 1'b1;
        strobe.cinSel  = CIN_ONE;
        strobe.borrow  = 1'b1;
      end
      OP_SBB: begin
        strobe.bInvert = 1'b1;
        strobe.cinSel  = CIN_NCY;
        strobe.borrow  = 1'b1;
      end
      OP_INC: begin
        strobe.bConst  = 1'b1;
        strobe.cinSel  = CIN_ONE;
        strobe.wrCarry = 1'b0;
      end
      OP_DEC: begin
        strobe.bConst  = 1'b1;
        strobe.bInvert = 1'b1;
        strobe.wrCarry = 1'b0;
      end
      OP_CPL: begin
        strobe.resSel  = RES_CPL;
        strobe.wrArith = 1'b0;
        strobe.wrCarry = 1'b0;
      end
      OP_RLC: begin
        strobe.resSel  = RES_ROT;
        strobe.wrArith = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DW-1:0]     accIn,
  input  logic [DW-1:0]     operandIn,
  input  aluStrobe_t        strobe,
  input  logic [FLAG_W-1:0] flagsCur,
  output logic [DW-1:0]     result,
  output logic [FLAG_W-1:0] flagsNext
);

  logic [DW-1:0]    bOp;
  logic             cin;
  logic [DW:0]      sumFull;
  logic [NIB_W:0]   lowSum;
  logic             newCarry;

  always_comb begin
    bOp = strobe.bConst ? '0 : operandIn;
    if (strobe.bInvert) bOp = ~bOp;
  end

  always_comb begin
    unique case (strobe.cinSel)
      CIN_ZERO: cin = 1'b0;
      CIN_ONE:  cin = 1'b1;
      CIN_CY:   cin = flagsCur[FLG_CY];
      CIN_NCY:  cin = ~flagsCur[FLG_CY];
      default:  cin = 1'b0;
    endcase
  end

  assign sumFull = {1'b0, accIn} + {1'b0, bOp} + {{DW{1'b0}}, cin};
  assign lowSum  = {1'b0, accIn[NIB_W-1:0]} + {1'b0, bOp[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, cin};

  always_comb begin
    unique case (strobe.resSel)
      RES_CPL: result = ~accIn;
      RES_ROT: result = {accIn[DW-2:0], accIn[DW-1]};
      default: result = sumFull[DW-1:0];
    endcase
  end

  assign newCarry = (strobe.resSel == RES_ROT) ? accIn[DW-1]
                                               : (sumFull[DW] ^ strobe.borrow);

  always_comb begin
    flagsNext = flagsCur;
    if (strobe.wrArith) begin
      flagsNext[FLG_S]  = result[DW-1];
      flagsNext[FLG_Z]  = (result == '0);
      flagsNext[FLG_AC] = lowSum[NIB_W];
      flagsNext[FLG_P]  = ~^result;
    end
    if (strobe.wrCarry) flagsNext[FLG_CY] = newCarry;
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic [DW-1:0]     accIn,
  input  logic [DW-1:0]     operandIn,
  output logic [DW-1:0]     result,
  output logic [FLAG_W-1:0] flagsNext,
  output logic [FLAG_W-1:0] flagsOut
);

  aluStrobe_t        strobe;
  logic [FLAG_W-1:0] flagReg;

  acc_alu_ctrl ctrl_i (
    .opSel  (opSel),
    .strobe (strobe)
  );

  acc_alu_dp #(.DW(DW)) dp_i (
    .accIn     (accIn),
    .operandIn (operandIn),
    .strobe    (strobe),
    .flagsCur  (flagReg),
    .result    (result),
    .flagsNext (flagsNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagReg <= '0;
    else if (opValid) flagReg <= flagsNext;
  end

  assign flagsOut = flagReg;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          opValid,
  input logic [2:0]    opSel,
  input logic [DW-1:0] accIn,
  input logic [DW-1:0] result,
  input logic [4:0]    flagsNext,
  input logic [4:0]    flagsOut
);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flagsOut));

  a_r9_commit: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> flagsOut == $past(flagsNext));

  a_r7_cpl_flags: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd6) |=> flagsOut == $past(flagsOut));

  a_r7_cpl_value: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 3'd6) |-> result == ~accIn);

  a_r6_keep_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == 3'd4 || opSel == 3'd5)) |=> flagsOut[0] == $past(flagsOut[0]));

  a_r8_rot_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd7) |=> flagsOut[0] == $past(accIn[DW-1]));

  a_r8_rot_keep: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd7) |=> flagsOut[4:1] == $past(flagsOut[4:1]));

  a_r4_zero: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel < 3'd6) |=> flagsOut[3] == ($past(result) == '0));

  a_r4_sign: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel < 3'd6) |=> flagsOut[4] == $past(result[DW-1]));

  a_r5_parity: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel < 3'd6) |=> flagsOut[1] == ~^$past(result));

endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opSel     (opSel),
  .accIn     (accIn),
  .result    (result),
  .flagsNext (flagsNext),
  .flagsOut  (flagsOut)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [2:0] opSel = 3'd0;
  logic [7:0] accIn = 8'd0;
  logic [7:0] operandIn = 8'd0;
  logic [7:0] result;
  logic [4:0] flagsNext;
  logic [4:0] flagsOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [4:0] mFlags = 5'd0;   // model of stored flags

  always #4 clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .accIn(accIn), .operandIn(operandIn), .result(result),
    .flagsNext(flagsNext), .flagsOut(flagsOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string resReq(input int op);
    case (op)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5: return "R6";
      6:    return "R7";
      default: return "R8";
    endcase
  endfunction

  // Behavioural reference; flag order S,Z,AC,P,CY from bit 4 down (R9)
  task automatic model(input int op, input int a, input int b, input logic [4:0] f,
                       output int res, output logic [4:0] nf);
    int cy, addend, cin, total, ones;
    bit arith;
    cy = f[0];
    nf = f;
    arith = 1;
    addend = 0; cin = 0;
    case (op)
      0: begin addend = b; cin = 0; end
      1: begin addend = b; cin = cy; end
      2: begin addend = 255 - b; cin = 1; end
      3: begin addend = 255 - b; cin = 1 - cy; end
      4: begin addend = 0; cin = 1; end
      5: begin addend = 255; cin = 0; end
      default: arith = 0;
    endcase
    if (arith) begin
      total = a + addend + cin;
      res = total % 256;
      if (op <= 1) nf[0] = (total > 255);
      if (op == 2) nf[0] = (a - b < 0);
      if (op == 3) nf[0] = (a - b - cy < 0);
      nf[4] = (res >= 128);
      nf[3] = (res == 0);
      nf[2] = (((a % 16) + (addend % 16) + cin) > 15);
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
      nf[1] = (ones % 2 == 0);
    end else if (op == 6) begin
      res = 255 - a;
    end else begin
      res = ((a * 2) % 256) + (a / 128);
      nf[0] = (a >= 128);
    end
  endtask

  task automatic step(input int op, input int a, input int b, input bit v);
    int expRes;
    logic [4:0] expF;
    string rq;
    @(negedge clk);
    opSel = op[2:0]; accIn = a[7:0]; operandIn = b[7:0]; opValid = v;
    #1;
    model(op, a, b, mFlags, expRes, expF);
    rq = resReq(op);
    check(rq, "result", int'(result), expRes);
    check("R4", "sign", int'(flagsNext[4]), int'(expF[4]));
    check("R4", "zero", int'(flagsNext[3]), int'(expF[3]));
    check("R3", "aux", int'(flagsNext[2]), int'(expF[2]));
    check("R5", "parity", int'(flagsNext[1]), int'(expF[1]));
    check(rq, "carry", int'(flagsNext[0]), int'(expF[0]));
    @(posedge clk);
    if (v) mFlags = expF;
    #2;
    check("R9", "stored flags", int'(flagsOut), int'(mFlags));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R9", "reset flags", int'(flagsOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    // worked examples
    step(0, 'h15, 'h27, 1);   // R1: 3C, P=1
    step(0, 'h30, 'h15, 1);   // R5: 45, P=0
    step(0, 'h8A, 'h28, 1);   // R3: B2, AC=1
    step(7, 'h80, 'h00, 1);   // R8: CY=1
    step(1, 'h4C, 'h25, 1);   // R1: with carry gives 72
    step(2, 'h15, 'h27, 1);   // R2: EE, borrow
    step(3, 'h3A, 'h15, 1);   // R2: 24, borrow clears
    step(7, 'h81, 'h00, 1);   // R8: CY=1 again
    step(4, 'hFF, 'h00, 1);   // R6: 00, CY kept
    step(5, 'h00, 'h00, 1);   // R6: FF, CY kept
    step(6, 'h5A, 'h00, 1);   // R7
    step(0, 'hFF, 'h01, 0);   // R9: no commit
    step(3, 'h29, 'h28, 1);   // R2: with CY=1 gives 00
    step(0, 'hFF, 'hFF, 1);   // R1: carry out
    for (int n = 0; n < 4000; n++)
      step(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), ($urandom_range(0, 9) < 8));
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule